// File: doc/BRIEF.md
# Cascadable Serial Segment Data Loader

This block collects display bits from a one-bit serial stream and holds them as a parallel segment pattern. Each enabled clock edge moves the stream one place along a 160-stage shift chain. A level-sensitive load control copies the chain into a 160-bit pattern register. That register keeps the last pattern while the next one is shifted in.

The chain has two taps, one at stage 80 and one at stage 160. Several loaders can be chained by feeding one tap into the serial input of the next loader. Which tap applies depends on the display mode. With one bank of 80 segments (static mode) the stage-80 tap is used. With two banks of 80 segments (two-phase multiplexed mode) the stage-160 tap is used. A mode input selects the tap that is driven onto the chain output.

Segment waveform generation, common-plane timing and analog drive levels are handled outside this block. The host sends the highest segment first and segment 1 last.

Top module: `seg_loader_top`

## Requirements
- R1: On a rising clock edge with `shift_en` high, `ser_in` is captured into stage 1 and every stage n takes the value of stage n-1. With `shift_en` low the chain holds and `ser_in` has no effect.
- R2: The chain has 160 stages. A bit reaches stage 160 after exactly 160 enabled shifts, and is not there after 159.
- R3: On an edge with `load_en` high, `pattern_o` takes the chain contents as they stand after that edge, including any shift made on the same edge. While `load_en` stays high, `pattern_o` follows the chain on every edge.
- R4: While `load_en` is low, `pattern_o` keeps its last value whatever is shifted in.
- R5: `tap_mid_o` equals the content of stage 80. It changes only at a rising clock edge.
- R6: `tap_end_o` equals the content of stage 160. It changes only at a rising clock edge.
- R7: `chain_o` equals `tap_end_o` when `dual_mode` is 1 (two-bank mode) and `tap_mid_o` when it is 0 (static mode).
- R8: Stage n drives `pattern_o` bit n-1, so the last bit shifted in lands at bit 0 (segment 1). Bits 79..0 form bank A and bits 159..80 form bank B. A 1 means the segment is on and a 0 means it is off.
- R9: A synchronous active-high `rst` clears the chain and `pattern_o` to all zeros (all off) at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| shift_en | input | 1 | shift strobe; qualifies the clock edge |
| ser_in | input | 1 | serial segment data |
| load_en | input | 1 | level-sensitive pattern load |
| dual_mode | input | 1 | 1 = two-bank mode, 0 = static mode |
| pattern_o | output | 160 | held segment pattern, bit 0 = segment 1 |
| tap_mid_o | output | 1 | stage-80 cascade tap |
| tap_end_o | output | 1 | stage-160 cascade tap |
| chain_o | output | 1 | tap selected by mode |

## Verification
The exact cycle in which a bit arrives at the stage-80 and stage-160 taps cannot be seen from the ports except by counting shifts. The stimulus therefore starts from a cleared chain and injects a single 1. It then checks each tap one shift before the expected arrival and again on the arrival shift. Transparent loading, where a shift and a load happen on the same edge, is exercised by holding `load_en` high during a shift burst. Each edge of that burst is compared against an independent model of the chain.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  localparam int unsigned SEG_STAGES_DEF = 160;
  localparam int unsigned SEG_BANK_DEF   = 80;

  typedef enum logic {
    MODE_STATIC = 1'b0,
    MODE_DUAL   = 1'b1
  } disp_mode_e;
endpackage

// File: rtl/seg_shift_chain.sv
module seg_shift_chain #(
  parameter int unsigned STAGES = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              ser_in,
  output logic [STAGES-1:0] chain_q,
  output logic [STAGES-1:0] chain_d
);
  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[STAGES-2:0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= chain_d;
  end

  // R1: an enabled edge captures the serial input into stage 1
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> chain_q[0] == $past(ser_in));
  // R1: without the strobe the chain stands still
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain_q));
  // R9: reset clears the chain
  p_clear_r9: assert property (@(posedge clk)
    rst |=> chain_q == '0);
endmodule

// File: rtl/seg_pattern_latch.sv
module seg_pattern_latch #(
  parameter int unsigned STAGES = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [STAGES-1:0] chain_d,
  input  logic [STAGES-1:0] chain_q,
  output logic [STAGES-1:0] pattern_q
);
  always_ff @(posedge clk) begin
    if (rst)          pattern_q <= '0;
    else if (load_en) pattern_q <= chain_d;
  end

  // R3: after a load edge the pattern matches the chain
  p_follow_r3: assert property (@(posedge clk) disable iff (rst)
    load_en |=> pattern_q == chain_q);
  // R4: no load, no change
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(pattern_q));
  // R9: reset clears the pattern
  p_clear_r9: assert property (@(posedge clk)
    rst |=> pattern_q == '0);
endmodule

// File: rtl/seg_cascade_taps.sv
module seg_cascade_taps #(
  parameter int unsigned STAGES = 160,
  parameter int unsigned BANK   = 80
) (
  input  logic              dual_mode,
  input  logic [STAGES-1:0] chain_q,
  output logic              tap_mid,
  output logic              tap_end,
  output logic              chain_out
);
  import seg_loader_pkg::*;
  disp_mode_e mode;

  assign mode      = disp_mode_e'(dual_mode);
  assign tap_mid   = chain_q[BANK-1];
  assign tap_end   = chain_q[STAGES-1];
  assign chain_out = (mode == MODE_DUAL) ? tap_end : tap_mid;
endmodule

// File: rtl/seg_loader_top.sv
module seg_loader_top #(
  parameter int unsigned STAGES = seg_loader_pkg::SEG_STAGES_DEF,
  parameter int unsigned BANK   = seg_loader_pkg::SEG_BANK_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic              load_en,
  input  logic              dual_mode,
  output logic [STAGES-1:0] pattern_o,
  output logic              tap_mid_o,
  output logic              tap_end_o,
  output logic              chain_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  seg_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .chain_q(chain_q), .chain_d(chain_d)
  );

  seg_pattern_latch #(.STAGES(STAGES)) u_latch (
    .clk(clk), .rst(rst), .load_en(load_en),
    .chain_d(chain_d), .chain_q(chain_q), .pattern_q(pattern_o)
  );

  seg_cascade_taps #(.STAGES(STAGES), .BANK(BANK)) u_taps (
    .dual_mode(dual_mode), .chain_q(chain_q),
    .tap_mid(tap_mid_o), .tap_end(tap_end_o), .chain_out(chain_o)
  );

  // R5: the middle tap takes the previous occupant of the stage before it
  p_mid_step_r5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> tap_mid_o == $past(chain_q[BANK-2]));
  // R6: the end tap takes the previous occupant of the stage before it
  p_end_step_r6: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> tap_end_o == $past(chain_q[STAGES-2]));
endmodule

// File: tb/seg_loader_top_tb_top.sv
module seg_loader_top_tb_top;
  localparam int N = 160;
  localparam int B = 80;

  localparam logic [N-1:0] VEC_TBL [4] = '{
    {{B{1'b0}}, {B{1'b1}}},
    {40{4'hA}},
    {20{8'h3C}},
    {{B{1'b1}}, 76'h0, 4'h5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0, ser_in = 1'b0, load_en = 1'b0, dual_mode = 1'b0;
  logic [N-1:0] pattern_o;
  logic tap_mid_o, tap_end_o, chain_o;

  int applied = 0;
  int bad = 0;
  logic [N-1:0] m_sr = '0;
  logic [N-1:0] m_pat = '0;

  always #4 clk = ~clk;

  seg_loader_top dut_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .load_en(load_en), .dual_mode(dual_mode), .pattern_o(pattern_o),
    .tap_mid_o(tap_mid_o), .tap_end_o(tap_end_o), .chain_o(chain_o)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, let one rising edge pass, sample 1 ns after it
  task automatic step(input logic en, input logic d, input logic ld);
    @(negedge clk);
    shift_en = en; ser_in = d; load_en = ld;
    @(posedge clk);
    #1;
    if (rst) begin
      m_sr = '0; m_pat = '0;
    end else begin
      if (en) m_sr = {m_sr[N-2:0], d};
      if (ld) m_pat = m_sr;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R9 reset pattern", pattern_o, '0);
    check("R9 reset taps", {158'h0, tap_mid_o, tap_end_o}, '0);

    // table walk: shift each vector highest bit first, then load
    foreach (VEC_TBL[v]) begin
      for (int i = N - 1; i >= 0; i--) step(1'b1, VEC_TBL[v][i], 1'b0);
      check("R4 pattern held while shifting", pattern_o, m_pat);
      check("R6 end tap holds first bit", {159'h0, tap_end_o}, {159'h0, VEC_TBL[v][N-1]});
      check("R5 mid tap holds stage 80", {159'h0, tap_mid_o}, {159'h0, VEC_TBL[v][B-1]});
      step(1'b0, 1'b0, 1'b1);
      check("R3 R8 loaded pattern order", pattern_o, VEC_TBL[v]);
    end

    // R1: no strobe, toggling input has no effect
    for (int i = 0; i < 4; i++) step(1'b0, i[0], 1'b1);
    check("R1 chain held without strobe", pattern_o, VEC_TBL[3]);

    // R2/R5/R6: single one travelling from a clear chain
    do_reset();
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < B - 2; i++) step(1'b1, 1'b0, 1'b0);
    check("R5 mid tap before arrival (79 shifts)", {159'h0, tap_mid_o}, '0);
    step(1'b1, 1'b0, 1'b0);
    check("R5 mid tap on arrival (80 shifts)", {159'h0, tap_mid_o}, 160'h1);
    dual_mode = 1'b0; #1;
    check("R7 static mode selects mid tap", {159'h0, chain_o}, 160'h1);
    dual_mode = 1'b1; #1;
    check("R7 dual mode selects end tap", {159'h0, chain_o}, '0);
    for (int i = 0; i < B - 1; i++) step(1'b1, 1'b0, 1'b0);
    check("R2 end tap before arrival (159 shifts)", {159'h0, tap_end_o}, '0);
    step(1'b1, 1'b0, 1'b0);
    check("R2 R6 end tap on arrival (160 shifts)", {159'h0, tap_end_o}, 160'h1);
    check("R7 dual mode passes end tap", {159'h0, chain_o}, 160'h1);
    dual_mode = 1'b0; #1;
    check("R7 static mode passes mid tap", {159'h0, chain_o}, '0);

    // R8: last bit shifted lands in bit 0, bank A vs bank B
    do_reset();
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    check("R8 last bit at segment 1", pattern_o, 160'h1);

    // R3: transparent while load held high, shift and load on the same edge
    for (int i = 0; i < 12; i++) begin
      step(1'b1, i[1] ^ i[0], 1'b1);
      check("R3 transparent follow", pattern_o, m_sr);
    end

    // R4: load low, more shifts, pattern unchanged
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b0);
    check("R4 hold after load drop", pattern_o, m_pat);

    // R9: reset in mid-stream
    do_reset();
    check("R9 mid-stream reset pattern", pattern_o, '0);
    check("R9 mid-stream reset taps", {158'h0, tap_mid_o, tap_end_o}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule